// File: doc/BRIEF.md
# Port Operating Mode Change Controller

This controller sequences a change of a switch port's operating mode when the change is carried out with a hot reset. A request strobe captures the previous and the new mode of the port. The controller then issues a single-cycle soft reset to the port's non-sticky state. It leaves sticky and software-sticky state alone, because it never drives any reset that reaches them.

Next, the controller tells the link training state machine where to go. Hot reset is used only when the port stays a downstream switch port. Every other pair of modes goes through Detect. The port is then held in reset for a fixed period of 250 µs, counted in clock cycles. If the new mode is operational (upstream or downstream), training is started in the matching direction. The controller returns to idle with a one-cycle done pulse.

The link state machine, the register file and the drain timers are outside this block. They exchange only level and strobe signals with it. A request that arrives while a change is in progress is dropped, and the drop is flagged.

Top module: `pmc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, busy_o, done_o, soft_rst_o, train_en_o, req_err_o are 0 and link_dir_o is 0 (no directive).
- R2: A request sampled while idle makes soft_rst_o high for exactly the next cycle, together with busy_o; this pulse is the only reset the controller issues.
- R3: Mode encoding is 0 upstream, 1 downstream, 2 unattached, 3 disabled. When old and new mode are both 1, link_dir_o is 2 (hot reset) from the cycle after the soft reset pulse until the cycle after link_hotrst_done_i is sampled high.
- R4: For every other mode pair, link_dir_o never shows 2; it shows 1 (Detect) starting in the cycle right after the soft reset pulse.
- R5: If link_train_fail_i is sampled high while hot reset is directed, the controller falls back to directing Detect (link_dir_o = 1) from the next cycle.
- R6: The reset hold lasts exactly HOLD_CYC cycles (default 125 MHz × 250 µs = 31250), during which link_dir_o is 1, busy_o is 1 and train_en_o is 0.
- R7: After the hold, an operational new mode (0 or 1) raises train_en_o with train_dn_o = 1 for downstream and 0 for upstream, with link_dir_o = 0. Training stays enabled until link_l0_i or link_train_fail_i is sampled high.
- R8: After the hold, a non-operational new mode (2 or 3) returns to idle at once with no training.
- R9: On return to idle, done_o is high for exactly one cycle and busy_o is low in that cycle.
- R10: A request sampled while busy is ignored: req_err_o pulses high for one cycle, and the sequence in progress keeps its timing.
- R11: Mode inputs are captured when the request is accepted; later changes on them have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Mode-change request strobe |
| old_mode_i | input | 2 | Operating mode before the change |
| new_mode_i | input | 2 | Operating mode after the change |
| link_l0_i | input | 1 | Link reached L0 |
| link_hotrst_done_i | input | 1 | Link completed hot reset |
| link_train_fail_i | input | 1 | Link could not reach the target state |
| soft_rst_o | output | 1 | One-cycle reset of non-sticky port state |
| link_dir_o | output | 2 | Link directive: 0 none, 1 Detect, 2 hot reset |
| train_en_o | output | 1 | Training enabled after the hold |
| train_dn_o | output | 1 | Training direction, 1 downstream |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_err_o | output | 1 | Request dropped because busy |

## Verification
A wrong state shows on link_dir_o within one cycle. The fault appears as a hot-reset directive on a mode pair that must use Detect, or as a Detect directive too early or too late. A miscounted hold moves the rise of train_en_o or done_o off its computed cycle, and every cycle of the hold is compared against the expected value. Latching the modes at the wrong time shows up as a wrong training direction, because the mode inputs are scrambled right after each request. A restart caused by a request while busy stretches the hold and is caught by the same per-cycle comparison.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_UP    = 2'd0,
        MODE_DN    = 2'd1,
        MODE_UNATT = 2'd2,
        MODE_DIS   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        LNK_NONE   = 2'd0,
        LNK_DETECT = 2'd1,
        LNK_HOTRST = 2'd2
    } lnk_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRST,
        ST_HOT,
        ST_HOLD,
        ST_TRAIN
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [1:0] old_m;
        logic [1:0] new_m;
        logic       done;
        logic       err;
    } ctl_t;

endpackage

// File: rtl/pmc_path_sel.sv
module pmc_path_sel
    import pmc_pkg::*;
(
    input  logic [1:0] old_i,
    input  logic [1:0] new_i,
    output logic       use_hot_o,
    output logic       oper_o,
    output logic       dn_o
);
    mode_e old_m, new_m;

    always_comb begin
        old_m     = mode_e'(old_i);
        new_m     = mode_e'(new_i);
        // Hot reset only when the port stays downstream on both sides
        use_hot_o = (old_m == MODE_DN) && (new_m == MODE_DN);
        oper_o    = (new_m == MODE_UP) || (new_m == MODE_DN);
        dn_o      = (new_m == MODE_DN);
    end
endmodule

// File: rtl/pmc_hold_timer.sv
module pmc_hold_timer #(
    parameter int HOLD_CYC = 31250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        last_o = run_i && (cnt_q == LAST);
        if (!run_i || last_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int HOLD_US  = 250,
    parameter int HOLD_CYC = CLK_MHZ * HOLD_US
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] old_mode_i,
    input  logic [1:0] new_mode_i,
    input  logic       link_l0_i,
    input  logic       link_hotrst_done_i,
    input  logic       link_train_fail_i,
    output logic       soft_rst_o,
    output logic [1:0] link_dir_o,
    output logic       train_en_o,
    output logic       train_dn_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       req_err_o
);
    ctl_t ctl_d, ctl_q;
    logic use_hot, oper, dn, hold_last;

    pmc_path_sel u_path (
        .old_i     (ctl_q.old_m),
        .new_i     (ctl_q.new_m),
        .use_hot_o (use_hot),
        .oper_o    (oper),
        .dn_o      (dn)
    );

    pmc_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctl_q.st == ST_HOLD),
        .last_o (hold_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st    = ST_SRST;
                    ctl_d.old_m = old_mode_i;
                    ctl_d.new_m = new_mode_i;
                end
            end
            ST_SRST: begin
                ctl_d.st = use_hot ? ST_HOT : ST_HOLD;
            end
            ST_HOT: begin
                // Completion or failure both end in the Detect hold
                if (link_hotrst_done_i || link_train_fail_i) ctl_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_last) begin
                    if (oper) begin
                        ctl_d.st = ST_TRAIN;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            ST_TRAIN: begin
                if (link_l0_i || link_train_fail_i) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (ctl_q.st != ST_IDLE && req_i) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, old_m: 2'd0, new_m: 2'd0, done: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        busy_o     = (ctl_q.st != ST_IDLE);
        soft_rst_o = (ctl_q.st == ST_SRST);
        train_en_o = (ctl_q.st == ST_TRAIN);
        train_dn_o = train_en_o && dn;
        done_o     = ctl_q.done;
        req_err_o  = ctl_q.err;
        case (ctl_q.st)
            ST_HOT:  link_dir_o = LNK_HOTRST;
            ST_HOLD: link_dir_o = LNK_DETECT;
            default: link_dir_o = LNK_NONE;
        endcase
    end
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic [1:0] old_mode_i,
    input logic [1:0] new_mode_i,
    input logic       link_l0_i,
    input logic       link_hotrst_done_i,
    input logic       link_train_fail_i,
    input logic       soft_rst_o,
    input logic [1:0] link_dir_o,
    input logic       train_en_o,
    input logic       train_dn_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       req_err_o
);
    // R2
    soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (busy_o && !soft_rst_o));

    // R2
    soft_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(req_i && !busy_o));

    // R5
    hot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_dir_o == 2'd2) |=> (link_dir_o == 2'd2 || link_dir_o == 2'd1));

    // R7
    train_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_en_o |-> (link_dir_o == 2'd0 && busy_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err_o |-> $past(req_i && busy_o));

    // R4
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_rst_o, train_en_o, link_dir_o != 2'd0, done_o}));
endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (.*);

// File: tb/pmc_ctrl_tb.sv
`timescale 1ns/1ps
module pmc_ctrl_tb;
    localparam int HC = 8;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic [1:0] om = 2'd0, nm = 2'd0;
    logic l0 = 1'b0, hd = 1'b0, tf = 1'b0;
    logic soft_rst, train_en, train_dn, busy, done, req_err;
    logic [1:0] link_dir;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pmc_ctrl #(.HOLD_CYC(HC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .old_mode_i(om), .new_mode_i(nm),
        .link_l0_i(l0), .link_hotrst_done_i(hd), .link_train_fail_i(tf),
        .soft_rst_o(soft_rst), .link_dir_o(link_dir), .train_en_o(train_en),
        .train_dn_o(train_dn), .busy_o(busy), .done_o(done), .req_err_o(req_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_pair(input logic [1:0] o, input logic [1:0] n,
                            input bit fail_hot, input bit fail_train, input bit inject);
        bit hot;
        bit op;
        hot = (o == 2'd1) && (n == 2'd1);
        op  = (n <= 2'd1);
        om = o; nm = n; req = 1'b1;
        step();
        req = 1'b0; om = ~o; nm = ~n;   // R11: scramble after acceptance
        chk("R2 soft reset pulse", soft_rst, 1);
        chk("R2 busy with pulse", busy, 1);
        chk("R4 no directive during pulse", link_dir, 0);
        step();
        if (hot) begin
            for (int i = 0; i < 3; i++) begin
                chk("R3 hot reset directed", link_dir, 2);
                chk("R2 pulse lasts one cycle", soft_rst, 0);
                if (i < 2) step();
            end
            if (fail_hot) tf = 1'b1; else hd = 1'b1;
            step();
            tf = 1'b0; hd = 1'b0;
        end else begin
            chk("R2 pulse lasts one cycle", soft_rst, 0);
        end
        for (int i = 0; i < HC; i++) begin
            chk(fail_hot ? "R5 fallback to detect" : (hot ? "R6 detect hold" : "R4 detect path"),
                link_dir, 1);
            chk("R6 no training in hold", train_en, 0);
            chk("R6 busy in hold", busy, 1);
            if (inject && i == 1) req = 1'b1;
            if (inject && i == 2) begin
                chk("R10 request dropped flagged", req_err, 1);
                req = 1'b0;
            end
            if (inject && i == 3) chk("R10 flag one cycle", req_err, 0);
            step();
        end
        if (op) begin
            chk("R7 training enabled", train_en, 1);
            chk("R7 R11 training direction", train_dn, (n == 2'd1) ? 1 : 0);
            chk("R7 no directive in training", link_dir, 0);
            chk("R9 no early done", done, 0);
            if (fail_train) tf = 1'b1; else l0 = 1'b1;
            step();
            tf = 1'b0; l0 = 1'b0;
        end
        chk("R9 done pulse", done, 1);
        chk("R9 busy low at done", busy, 0);
        chk("R8 training off at done", train_en, 0);
        chk("R8 no directive at done", link_dir, 0);
        step();
        chk("R9 done one cycle", done, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) step();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset soft", soft_rst, 0);
        chk("R1 reset link", link_dir, 0);
        rst_n = 1'b1;
        repeat (2) step();
        chk("R1 idle busy", busy, 0);
        chk("R1 idle train", train_en, 0);
        chk("R1 idle err", req_err, 0);
        chk("R1 idle done", done, 0);
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                run_pair(2'(o), 2'(n), 1'b0, 1'b0, ((o ^ n) == 1));
            end
        end
        run_pair(2'd1, 2'd1, 1'b1, 1'b0, 1'b0);
        run_pair(2'd1, 2'd1, 1'b1, 1'b1, 1'b1);
        run_pair(2'd0, 2'd1, 1'b0, 1'b1, 1'b0);
        run_pair(2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule